// File: doc/BRIEF.md
# Watchdog Timer with Assignable Prescaler

This block is a watchdog timer that counts ticks from its own slow clock-enable strobe. One unscaled watchdog period is a fixed number of ticks, derived from the tick rate so that it lasts 18 ms. An optional power-of-two prescaler can be placed in front of the period counter, stretching the period by up to 128 times (about 2.3 s at the nominal rate). Software keeps the watchdog from expiring by issuing a clear strobe, which restarts both the prescaler and the period counter.

A sleep-entry strobe also restarts both stages and marks the block as sleeping, so the full configured period is available before the wake-up request. An expiry while running raises a one-cycle reset request. An expiry while sleeping raises a one-cycle wake request instead, and sleep mode ends. A sticky flag records that an expiry happened and stays set until the next clear strobe.

Top module: `wdog_presc`

## Requirements
- R1: While reset is held and in the first cycle after it, `rst_req_o`, `wake_req_o` and `expired_o` are 0.
- R2: With `pre_assign_i` = 0, an expiry occurs on the BASE_TICKS-th tick after a restart (BASE_TICKS = TICK_HZ * PERIOD_US / 1e6; 36 by default), whatever the value of `ratio_i`.
- R3: With `pre_assign_i` = 1, ratio code k on `ratio_i` (0 to 7) divides the tick by 2^k, so that the expiry falls on tick BASE_TICKS * 2^k after a restart.
- R4: Counting advances only in cycles where `tick_i` is 1. An expiry is reported in the cycle right after the tick that completes the period.
- R5: `clr_i` restarts both the prescaler and the period counter and takes priority over a tick in the same cycle. The next expiry falls a full period after the cycle of the clear.
- R6: `sleep_i` restarts both stages and enters sleep. An expiry during sleep pulses `wake_req_o` instead of `rst_req_o` and ends sleep.
- R7: An expiry while awake pulses `rst_req_o` for exactly one cycle. `rst_req_o` and `wake_req_o` are never 1 together.
- R8: `expired_o` is set by any expiry, holds while `clr_i` is 0, and reads 0 in the cycle after a clear.
- R9: While `en_i` is 0, both stages are held at zero and no expiry occurs. After `en_i` rises, a full period is needed before the next expiry.
- R10: Without a clear, the watchdog keeps running after an expiry, and further expiries follow one full period apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow-oscillator clock-enable strobe |
| clr_i | input | 1 | Clear-watchdog strobe |
| sleep_i | input | 1 | Sleep-entry strobe |
| en_i | input | 1 | Watchdog enable |
| pre_assign_i | input | 1 | 1 places the prescaler in front of the counter |
| ratio_i | input | RATIO_W | Prescale code k, divide by 2^k |
| rst_req_o | output | 1 | One-cycle reset request (expiry while awake) |
| wake_req_o | output | 1 | One-cycle wake request (expiry while asleep) |
| expired_o | output | 1 | Sticky expiry flag, cleared by clr_i |

## Verification
The watchdog is run with a continuous tick and with a tick every third cycle. It is also run with the prescaler unassigned while the ratio code is held at its maximum, and with ratio codes 0, 3 and 7 assigned. Between them, these runs separate a counter that ignores the tick gating, a prescaler applied when it should not be, and a shift that is off by one. Clears and sleep entries are issued in the middle of a prescaler cycle, where a prescaler that is not reset would make the expiry come early. Disabling the watchdog over several periods, followed by a free run across three periods, shows whether the restart and the periodic wrap behave as required.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_RESET = 2'd1,
    EV_WAKE  = 2'd2
  } wdog_evt_e;

  function automatic int unsigned base_ticks(int unsigned tick_hz, int unsigned period_us);
    longint unsigned prod;
    prod = longint'(tick_hz) * longint'(period_us);
    return int'(prod / 64'd1000000);
  endfunction
endpackage

// File: rtl/wdog_prediv.sv
module wdog_prediv #(
  parameter int unsigned RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               tick_i,
  input  logic               bypass_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               step_o
);
  localparam int unsigned PRE_W = (1 << RATIO_W) - 1;
  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   one_hot;
  logic [PRE_W-1:0] mask;
  logic             at_top;

  assign one_hot = (PRE_W+1)'(1) << ratio_i;
  assign mask    = one_hot[PRE_W-1:0] - ONE;
  // >= so that a ratio lowered mid-count still terminates
  assign at_top  = (pre_q >= mask);
  assign step_o  = tick_i & ~clear_i & (bypass_i | at_top);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (clear_i || bypass_i) begin
      pre_q <= '0;
    end else if (tick_i) begin
      pre_q <= at_top ? '0 : pre_q + ONE;
    end
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned BASE = 36
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic adv_i,
  output logic wrap_o
);
  localparam int unsigned CNT_W = (BASE > 2) ? $clog2(BASE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BASE - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = adv_i & ~clear_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (adv_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + ONE;
    end
  end
endmodule

// File: rtl/wdog_presc.sv
module wdog_presc
  import wdog_pkg::*;
#(
  parameter int unsigned TICK_HZ   = 2000,
  parameter int unsigned PERIOD_US = 18000,
  parameter int unsigned RATIO_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               clr_i,
  input  logic               sleep_i,
  input  logic               en_i,
  input  logic               pre_assign_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               rst_req_o,
  output logic               wake_req_o,
  output logic               expired_o
);
  localparam int unsigned BASE_TICKS = base_ticks(TICK_HZ, PERIOD_US);

  logic      restart;
  logic      step;
  logic      expire;
  logic      asleep_q;
  logic      rst_req_q, wake_req_q, flag_q;
  wdog_evt_e evt;

  assign restart = clr_i | sleep_i | ~en_i;

  wdog_prediv #(.RATIO_W(RATIO_W)) u_prediv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (restart),
    .tick_i   (tick_i),
    .bypass_i (~pre_assign_i),
    .ratio_i  (ratio_i),
    .step_o   (step)
  );

  wdog_count #(.BASE(BASE_TICKS)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart),
    .adv_i   (step),
    .wrap_o  (expire)
  );

  always_comb begin
    evt = EV_NONE;
    if (expire) evt = asleep_q ? EV_WAKE : EV_RESET;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asleep_q   <= 1'b0;
      rst_req_q  <= 1'b0;
      wake_req_q <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      rst_req_q  <= (evt == EV_RESET);
      wake_req_q <= (evt == EV_WAKE);
      if (sleep_i)              asleep_q <= 1'b1;
      else if (evt == EV_WAKE)  asleep_q <= 1'b0;
      if (clr_i)                flag_q <= 1'b0;
      else if (expire)          flag_q <= 1'b1;
    end
  end

  assign rst_req_o  = rst_req_q;
  assign wake_req_o = wake_req_q;
  assign expired_o  = flag_q;
endmodule

// File: rtl/wdog_presc_chk.sv
module wdog_presc_chk #(
  parameter int unsigned RATIO_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               clr_i,
  input logic               sleep_i,
  input logic               en_i,
  input logic               pre_assign_i,
  input logic [RATIO_W-1:0] ratio_i,
  input logic               rst_req_o,
  input logic               wake_req_o,
  input logic               expired_o
);
  a_r7_reset_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  a_r6_wake_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |=> !wake_req_o);
  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_req_o && wake_req_o));
  a_r8_flag_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o || wake_req_o) |-> expired_o);
  a_r8_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !clr_i) |=> expired_o);
  a_r5_clear_quiets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!expired_o && !rst_req_o && !wake_req_o));
  a_r9_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!rst_req_o && !wake_req_o));
  a_r4_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (!rst_req_o && !wake_req_o));
  a_r6_sleep_no_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !rst_req_o);
endmodule

bind wdog_presc wdog_presc_chk #(.RATIO_W(RATIO_W)) u_chk (.*);

// File: tb/wdog_presc_test.sv
`timescale 1ns/1ps
module wdog_presc_test;
  localparam int unsigned BASE = 36;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       clr_i = 1'b0;
  logic       sleep_i = 1'b0;
  logic       en_i = 1'b0;
  logic       pre_assign_i = 1'b0;
  logic [2:0] ratio_i = 3'd0;
  logic       rst_req_o, wake_req_o, expired_o;

  always #2.5 clk = ~clk;

  wdog_presc uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .clr_i(clr_i),
    .sleep_i(sleep_i), .en_i(en_i), .pre_assign_i(pre_assign_i),
    .ratio_i(ratio_i), .rst_req_o(rst_req_o), .wake_req_o(wake_req_o),
    .expired_o(expired_o)
  );

  typedef struct {
    bit     wake;
    longint at;
    string  req;
  } exp_t;

  exp_t   q[$];
  int     checks = 0;
  int     fails = 0;
  longint cyc = 0;
  bit     tick_on = 1'b0;
  int     gap = 1;
  bit     done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tick_i <= tick_on && (((cyc + 1) % gap) == 0);

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint due(longint c, int n);
    longint first;
    first = (c / gap + 1) * gap;
    return first + longint'(n - 1) * gap;
  endfunction

  task automatic push(bit wake, longint at, string req);
    exp_t e;
    e.wake = wake; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && !done && (rst_req_o || wake_req_o)) begin
      if (rst_req_o && wake_req_o) chk(1'b0, "R7", "both requests high", 1, 0);
      if (q.size() == 0) begin
        chk(1'b0, "R7", "unexpected request at cycle", cyc, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(wake_req_o == e.wake, e.wake ? "R6" : "R7", "request kind wake",
            longint'(wake_req_o), longint'(e.wake));
        chk(cyc == e.at, e.req, "expiry cycle", cyc, e.at);
      end
    end
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_clear(output longint c);
    @(negedge clk) clr_i = 1'b1;
    @(negedge clk) clr_i = 1'b0;
    c = cyc;
  endtask

  task automatic start(bit pa, int r, int g, output longint c);
    @(negedge clk);
    pre_assign_i = pa; ratio_i = 3'(r); gap = g; tick_on = 1'b1; en_i = 1'b1;
    do_clear(c);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    longint c, c2;
    repeat (4) @(negedge clk);
    chk(!rst_req_o && !wake_req_o && !expired_o, "R1", "outputs in reset", 1, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(rst_req_o == 0, "R1", "rst_req after reset", rst_req_o, 0);
    chk(wake_req_o == 0, "R1", "wake_req after reset", wake_req_o, 0);
    chk(expired_o == 0, "R1", "flag after reset", expired_o, 0);

    // R2: unassigned prescaler, max ratio code ignored
    start(1'b0, 7, 1, c);
    push(1'b0, due(c, BASE), "R2");
    drain();
    chk(rst_req_o == 0, "R7", "pulse ended", rst_req_o, 0);
    chk(expired_o == 1, "R8", "flag set", expired_o, 1);
    repeat (10) @(negedge clk);
    chk(expired_o == 1, "R8", "flag held", expired_o, 1);
    do_clear(c);
    chk(expired_o == 0, "R8", "flag cleared", expired_o, 0);

    // R3: assigned ratios
    for (int i = 0; i < 3; i++) begin
      int r;
      r = (i == 0) ? 0 : (i == 1) ? 3 : 7;
      start(1'b1, r, 1, c);
      push(1'b0, due(c, BASE << r), "R3");
      drain();
    end

    // R4: sparse tick
    start(1'b1, 2, 3, c);
    push(1'b0, due(c, BASE * 4), "R4");
    drain();

    // R5: clear in mid prescaler cycle
    start(1'b1, 3, 1, c);
    repeat (101) @(negedge clk);
    chk(expired_o == 0, "R5", "no expiry before clear", expired_o, 0);
    do_clear(c2);
    push(1'b0, due(c2, BASE * 8), "R5");
    drain();

    // R6: sleep mid prescaler, wake then next reset
    start(1'b1, 2, 1, c);
    repeat (22) @(negedge clk);
    @(negedge clk) sleep_i = 1'b1;
    @(negedge clk) sleep_i = 1'b0;
    c2 = cyc;
    push(1'b1, due(c2, BASE * 4), "R6");
    push(1'b0, due(c2, BASE * 8), "R6");
    drain();
    chk(expired_o == 1, "R8", "flag after wake", expired_o, 1);

    // R9: disabled holds off expiry
    start(1'b1, 0, 1, c);
    @(negedge clk) en_i = 1'b0;
    repeat (200) @(negedge clk);
    chk(expired_o == 0, "R9", "flag while disabled", expired_o, 0);
    chk(q.size() == 0, "R9", "pending while disabled", q.size(), 0);
    @(negedge clk) en_i = 1'b1;
    c = cyc;
    push(1'b0, due(c, BASE), "R9");
    drain();

    // R10: free running over three periods
    start(1'b1, 1, 1, c);
    push(1'b0, due(c, BASE * 2), "R10");
    push(1'b0, due(c, BASE * 4), "R10");
    push(1'b0, due(c, BASE * 6), "R10");
    drain();
    @(negedge clk) en_i = 1'b0;
    repeat (50) @(negedge clk);
    chk(q.size() == 0, "R10", "queue empty at end", q.size(), 0);
    summary();
  end
endmodule